// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block merges several reset causes into one stretched processor reset. Three undervoltage monitor results arrive as digital "supply good" flags. They cover the main supply and two auxiliary supplies. A manual-reset button request and, as a build option, a watchdog expiry pulse are the other causes. While any cause is present the reset is asserted. Once every cause has cleared, the reset stays asserted for a hold time counted in clock cycles. After that it releases.

The supply flags and the button are asynchronous to the clock, so each one passes through a two-stage synchronizer before use. The watchdog request goes through the same pipeline, which keeps the latency the same for every cause. A cause that appears while the hold count is running reloads the count to its full nominal value, so the release is pushed out rather than cut short. Power-on reset (`arst_n`) puts the block into the asserted state. The block drives an active-low reset and an active-high copy of it.

Top module: `supv_reset_gen`

## Requirements
- R1: While `arst_n` is low, `rst_n_o` is 0. After `arst_n` rises with every cause clear, reset stays asserted for HOLD_NOM cycles and then releases.
- R2: A supply flag at 0 (main_ok, aux1_ok or aux2_ok; 0 means below threshold) asserts reset. The reset is visible after the third rising edge following the change, which is two synchronizer stages plus the state register.
- R3: `man_rst_n` at 0 asserts reset with the same latency, and the hold period applies after it returns to 1.
- R4: Counting the first rising edge that samples all causes clear as edge 1, reset deasserts on rising edge HOLD_NOM+2, which is exactly HOLD_NOM cycles of hold.
- R5: Any cause that appears during a running hold reloads the count to HOLD_NOM, measured from the new cause's last active cycle.
- R6: `rst_o` is the exact complement of `rst_n_o` in every cycle.
- R7: With WDOG_EN=1, a single-cycle high pulse on `wdog_trip` produces a reset pulse with the same latency and hold as the other causes.
- R8: While the synchronized main supply flag is 0, reset never releases, however long the supply stays low.
- R9: Causes that overlap, start together or clear in the same cycle give one unbroken reset interval with no release glitch between them.
- R10: A release never comes fewer than HOLD_MIN cycles after the last cause cleared (HOLD_MIN ≤ HOLD_NOM).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous power-on reset, active low |
| main_ok | input | 1 | Main supply above threshold (1) or below it (0), asynchronous |
| aux1_ok | input | 1 | Second supply above threshold (1) or below it (0), asynchronous |
| aux2_ok | input | 1 | Third supply above threshold (1) or below it (0), asynchronous |
| man_rst_n | input | 1 | Manual reset request, active low, asynchronous |
| wdog_trip | input | 1 | Watchdog expiry pulse, active high, used when WDOG_EN=1 |
| rst_n_o | output | 1 | Processor reset, active low |
| rst_o | output | 1 | Processor reset, active high |

## Verification
The hardest case to reach is a reload in the middle of the hold. A fresh cause must land while the counter is partway down, and the second supply can hand over to the third in the very same cycle. The stimulus drives causes on exact cycle counts relative to the previous release so that both of these events happen. The scoreboard then predicts every output cycle from the input history, using the three-edge latency and the HOLD_NOM window. Because every cycle is predicted, a premature release or a one-cycle gap between overlapping causes shows up as a mismatch.

// File: rtl/supv_pkg.sv
package supv_pkg;

   // Raw monitored inputs after synchronization (1 = healthy / not pressed)
   typedef struct packed {
      logic main_ok;
      logic aux1_ok;
      logic aux2_ok;
      logic man_n;
   } supv_flags_t;

   localparam int unsigned FLAG_W = $bits(supv_flags_t);

   // Active reset causes (1 = cause present)
   typedef struct packed {
      logic main_low;
      logic aux1_low;
      logic aux2_low;
      logic manual;
      logic wdog;
   } supv_cause_t;

   function automatic logic cause_any(input supv_cause_t c);
      return c.main_low | c.aux1_low | c.aux2_low | c.manual | c.wdog;
   endfunction

endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
   parameter int unsigned WIDTH   = 1,
   parameter int unsigned STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] stg [STAGES];

   initial begin
      assert (STAGES >= 2) else $error("supv_sync: STAGES must be at least 2");
      assert (WIDTH >= 1)  else $error("supv_sync: WIDTH must be at least 1");
   end

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge arst_n) begin
               if (!arst_n) stg[s] <= RST_VAL;
               else         stg[s] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge arst_n) begin
               if (!arst_n) stg[s] <= RST_VAL;
               else         stg[s] <= stg[s-1];
            end
         end
      end
   endgenerate

   assign q = stg[STAGES-1];

endmodule

// File: rtl/supv_cond_merge.sv
module supv_cond_merge
   import supv_pkg::*;
#(
   parameter bit WDOG_EN = 1'b1
) (
   input  supv_flags_t flags,
   input  logic        wdog_s,
   output supv_cause_t cause,
   output logic        any_cond
);

   always_comb begin
      cause.main_low = ~flags.main_ok;
      cause.aux1_low = ~flags.aux1_ok;
      cause.aux2_low = ~flags.aux2_ok;
      cause.manual   = ~flags.man_n;
   end

   generate
      if (WDOG_EN) begin : g_wdog
         assign cause.wdog = wdog_s;
      end else begin : g_no_wdog
         assign cause.wdog = 1'b0;
      end
   endgenerate

   assign any_cond = cause_any(cause);

endmodule

// File: rtl/supv_hold_timer.sv
module supv_hold_timer #(
   parameter int unsigned HOLD_NOM = 20,
   parameter int unsigned HOLD_MIN = 14
) (
   input  logic clk,
   input  logic arst_n,
   input  logic load,
   output logic held_o
);

   localparam int unsigned CNT_W = $clog2(HOLD_NOM + 1);
   localparam logic [CNT_W-1:0] NOM_V = CNT_W'(HOLD_NOM);

   logic [CNT_W-1:0] cnt_q;
   logic             held_q;

   initial begin
      assert (HOLD_NOM >= 1)        else $error("supv_hold_timer: HOLD_NOM must be >= 1");
      assert (HOLD_MIN >= 1)        else $error("supv_hold_timer: HOLD_MIN must be >= 1");
      assert (HOLD_MIN <= HOLD_NOM) else $error("supv_hold_timer: HOLD_MIN exceeds HOLD_NOM");
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         cnt_q  <= NOM_V;
         held_q <= 1'b1;
      end else if (load) begin
         cnt_q  <= NOM_V;
         held_q <= 1'b1;
      end else if (held_q) begin
         if (cnt_q <= CNT_W'(1)) begin
            cnt_q  <= '0;
            held_q <= 1'b0;
         end else begin
            cnt_q  <= cnt_q - CNT_W'(1);
         end
      end
   end

   assign held_o = held_q;

   // Quiet-cycle counter used only by the checks below
   logic [CNT_W-1:0] quiet_q;
   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)              quiet_q <= '0;
      else if (load || !held_q) quiet_q <= '0;
      else if (quiet_q != NOM_V) quiet_q <= quiet_q + CNT_W'(1);
   end

   AST_LOAD_ASSERTS: assert property (@(posedge clk) disable iff (!arst_n)
      load |=> held_q); // R2

   AST_MIN_HOLD: assert property (@(posedge clk) disable iff (!arst_n)
      (held_q && !load && (quiet_q < CNT_W'(HOLD_MIN - 1))) |=> held_q); // R10

   AST_EXACT_RELEASE: assert property (@(posedge clk) disable iff (!arst_n)
      (held_q && !load && (quiet_q == CNT_W'(HOLD_NOM - 1))) |=> !held_q); // R4

endmodule

// File: rtl/supv_reset_gen.sv
module supv_reset_gen
   import supv_pkg::*;
#(
   parameter int unsigned HOLD_NOM    = 20,
   parameter int unsigned HOLD_MIN    = 14,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          WDOG_EN     = 1'b1
) (
   input  logic clk,
   input  logic arst_n,
   input  logic main_ok,
   input  logic aux1_ok,
   input  logic aux2_ok,
   input  logic man_rst_n,
   input  logic wdog_trip,
   output logic rst_n_o,
   output logic rst_o
);

   supv_flags_t raw_flags;
   supv_flags_t sync_flags;
   logic        wdog_s;
   supv_cause_t cause;
   logic        any_cond;
   logic        held;

   assign raw_flags = '{main_ok: main_ok, aux1_ok: aux1_ok,
                        aux2_ok: aux2_ok, man_n: man_rst_n};

   // Monitor flags reset to "fault" so reset holds through power-on
   supv_sync #(.WIDTH(FLAG_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_flag_sync (
      .clk    (clk),
      .arst_n (arst_n),
      .d      (raw_flags),
      .q      (sync_flags)
   );

   // Same depth as the flags so every cause sees identical latency
   supv_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_wdog_sync (
      .clk    (clk),
      .arst_n (arst_n),
      .d      (wdog_trip),
      .q      (wdog_s)
   );

   supv_cond_merge #(.WDOG_EN(WDOG_EN)) u_merge (
      .flags    (sync_flags),
      .wdog_s   (wdog_s),
      .cause    (cause),
      .any_cond (any_cond)
   );

   supv_hold_timer #(.HOLD_NOM(HOLD_NOM), .HOLD_MIN(HOLD_MIN)) u_timer (
      .clk    (clk),
      .arst_n (arst_n),
      .load   (any_cond),
      .held_o (held)
   );

   assign rst_n_o = ~held;
   assign rst_o   = held;

   AST_MAIN_LOW_HOLDS: assert property (@(posedge clk) disable iff (!arst_n)
      !sync_flags.main_ok |=> !rst_n_o); // R8

   AST_MANUAL_HOLDS: assert property (@(posedge clk) disable iff (!arst_n)
      cause.manual |=> rst_o); // R3

endmodule

// File: tb/supv_reset_gen_bench.sv
module supv_reset_gen_bench;

   localparam int unsigned NOM = 12;
   localparam int unsigned MIN = 8;

   logic clk = 1'b0;
   logic arst_n = 1'b0;
   logic main_ok = 1'b1, aux1_ok = 1'b1, aux2_ok = 1'b1, man_rst_n = 1'b1, wdog_trip = 1'b0;
   logic rst_n_o, rst_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit mon_on = 1'b0;
   int n_idx = 1;
   int last_act = 0;

   typedef struct {
      bit    asserted;
      string tag;
   } item_t;
   item_t exp_q[$];

   always #4 clk = ~clk; // 125 MHz

   supv_reset_gen #(.HOLD_NOM(NOM), .HOLD_MIN(MIN)) u_supv_reset_gen (
      .clk       (clk),
      .arst_n    (arst_n),
      .main_ok   (main_ok),
      .aux1_ok   (aux1_ok),
      .aux2_ok   (aux2_ok),
      .man_rst_n (man_rst_n),
      .wdog_trip (wdog_trip),
      .rst_n_o   (rst_n_o),
      .rst_o     (rst_o)
   );

   task automatic push_exp(input bit a, input string tag);
      item_t it;
      it.asserted = a;
      it.tag = tag;
      exp_q.push_back(it);
   endtask

   // Driver: one cycle per iteration, prediction for three edges later
   task automatic drive(input bit m, input bit a1, input bit a2, input bit mr,
                        input bit wd, input string tag, input int cycles);
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         #1;
         main_ok = m; aux1_ok = a1; aux2_ok = a2; man_rst_n = mr; wdog_trip = wd;
         if (!m || !a1 || !a2 || !mr || wd) last_act = n_idx;
         push_exp((n_idx - last_act) <= int'(NOM) - 1, tag);
         n_idx++;
      end
   endtask

   task automatic quiet(input string tag, input int cycles);
      drive(1, 1, 1, 1, 0, tag, cycles);
   endtask

   // Monitor: pops one expected item per cycle and compares
   always @(negedge clk) begin
      if (mon_on && exp_q.size() > 0) begin
         item_t it;
         it = exp_q.pop_front();
         n_cmp++;
         if (rst_n_o !== !it.asserted) begin
            n_bad++;
            $display("FAIL %s: rst_n_o=%b expected %b (cycle %0d)", it.tag, rst_n_o, !it.asserted, n_idx);
         end
         n_cmp++;
         if (rst_o !== ~rst_n_o) begin
            n_bad++;
            $display("FAIL R6: rst_o=%b expected %b", rst_o, ~rst_n_o);
         end
      end
   end

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state while arst_n is low
      n_cmp++;
      if (rst_n_o !== 1'b0 || rst_o !== 1'b1) begin
         n_bad++;
         $display("FAIL R1: rst_n_o=%b rst_o=%b expected 0/1", rst_n_o, rst_o);
      end
      // release power-on reset with all causes clear
      @(negedge clk);
      #1;
      arst_n = 1'b1;
      push_exp(1'b1, "R1");
      push_exp(1'b1, "R1");
      mon_on = 1'b1;
      last_act = 0;
      n_idx = 1;
      push_exp((n_idx - last_act) <= int'(NOM) - 1, "R1");
      n_idx++;
      quiet("R1", NOM + 6);

      // R2: each supply alone, varied lengths
      drive(0, 1, 1, 1, 0, "R2", 3);  quiet("R2", NOM + 5);
      drive(1, 0, 1, 1, 0, "R2", 1);  quiet("R2", NOM + 5);
      drive(1, 1, 0, 1, 0, "R2", 5);  quiet("R2", NOM + 5);

      // R3: manual reset
      drive(1, 1, 1, 0, 0, "R3", 4);  quiet("R3", NOM + 5);

      // R4: exact release position after a single-cycle cause
      drive(1, 1, 1, 0, 0, "R4", 1);  quiet("R4", NOM + 4);

      // R5: new dip halfway through the hold reloads the count
      drive(1, 0, 1, 1, 0, "R5", 2);
      quiet("R5", NOM / 2);
      drive(0, 1, 1, 1, 0, "R5", 1);
      quiet("R5", NOM - 2);
      drive(1, 1, 1, 0, 0, "R5", 1);  // lands one cycle before release
      quiet("R5", NOM + 6);

      // R7: watchdog pulse
      drive(1, 1, 1, 1, 1, "R7", 1);  quiet("R7", NOM + 5);

      // R8: long main-supply low (power-down)
      drive(0, 1, 1, 1, 0, "R8", 3 * NOM);  quiet("R8", NOM + 5);

      // R9: overlapping starts and same-cycle clears
      drive(0, 1, 1, 0, 0, "R9", 4);
      drive(1, 0, 1, 1, 0, "R9", 3);   // handover in one cycle
      drive(1, 1, 0, 1, 1, "R9", 1);   // aux1 clears as aux2 falls, watchdog too
      drive(1, 1, 0, 1, 0, "R9", 2);
      quiet("R9", NOM + 5);
      drive(0, 0, 0, 0, 1, "R9", 2);   // all at once, all clear together
      quiet("R9", NOM + 6);

      repeat (4) @(negedge clk);
      finish_run();
   end

endmodule